// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two parallel ports, side A and side B, with one storage path for each direction. Each path works in one of three ways. In pass-through mode it follows its input. In hold mode it keeps the last stored word. In capture mode it samples its input on a rising edge of that direction's port clock. Each direction has four controls of its own: an active-low drive enable, a pass-through (latch) enable, a port clock and an active-low clock gate.

The whole block runs on a single fast system clock. The four control lines of each direction are treated as asynchronous. They pass through a two-flop synchronizer, and the port clock's rising edge is found by comparing two successive synchronized samples. Each output is a data bus together with a per-bit drive-enable vector. A tri-state pad wrapper can then be added at chip level, or left out. A status line is raised whenever both directions drive at the same time.

The data width is set by a parameter, and its default is 18 bits.

Top module: `bidir_store_xcvr`

## Requirements
- R1: While the synchronized latch enable of a direction is high, its output bus takes the value its input bus had at the previous system-clock edge (one register stage of latency).
- R2: While the latch enable is low and the active-low clock gate is low, a rising edge of the port clock loads the input word into that direction's storage.
- R3: While the latch enable is low and no rising port-clock edge is seen, the output bus keeps its stored value, whether the port clock stays high or stays low.
- R4: While the latch enable is low and the clock gate is high, the stored value is kept whatever the port clock does, rising edges included.
- R5: A low drive enable sets every bit of that direction's drive-enable vector to 1. A high drive enable clears every bit to 0 and leaves the stored data untouched.
- R6: A synchronous active-high reset clears both stored words to zero, clears both drive-enable vectors and the contention flag, and loads the synchronizers with their idle levels (drive disabled, latch closed, clock low, gate closed).
- R7: A change on any control input takes effect at the output on the third system-clock edge after it is applied, and not before.
- R8: When the latch enable falls while the port clock is high, the stored value is kept while the clock stays high and after the clock then falls. The next rising edge captures new data.
- R9: The B-to-A path (input b_in, outputs a_out/a_drv) behaves in the same way as the A-to-B path, using its own four controls, and neither path affects the other.
- R10: The contention output is high in exactly those cycles in which both drive-enable vectors are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Word read from side A, source of the A-to-B path |
| b_in | input | W | Word read from side B, source of the B-to-A path |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_pclk | input | 1 | A-to-B port clock |
| ab_cke_n | input | 1 | A-to-B clock gate, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_pclk | input | 1 | B-to-A port clock |
| ba_cke_n | input | 1 | B-to-A clock gate, active low |
| b_out | output | W | Stored A-to-B word presented to side B |
| b_drv | output | W | Per-bit drive enable for side B |
| a_out | output | W | Stored B-to-A word presented to side A |
| a_drv | output | W | Per-bit drive enable for side A |
| contention | output | 1 | High while both sides are driven |

## Verification
The case that is hardest to reach is the one where the latch closes while the port clock is already high. The storage must not count that high level as an edge. It must still take the next real rising edge once the clock has gone low and come back up. The stimulus sets up this case in steps. It opens the latch with the clock high, lets the synchronizer settle, and closes the latch with the clock still high. It then changes the input word, lowers the clock and raises it again. Between these steps it checks that the output held and then updated. It also checks that the first edge with the gate high was ignored and that a control change shows up no earlier than its third system-clock edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Per-direction control bundle, MSB first.
  typedef struct packed {
    logic cke_n;   // clock gate, active low
    logic pclk;    // port clock
    logic le;      // pass-through enable
    logic oe_n;    // drive enable, active low
  } xcvr_ctl_t;

  localparam int CTL_BITS = $bits(xcvr_ctl_t);

  // Idle levels loaded into the synchronizer under reset.
  localparam xcvr_ctl_t CTL_IDLE = '{cke_n: 1'b1, pclk: 1'b0, le: 1'b0, oe_n: 1'b1};

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  xcvr_ctl_t    ctl,   // already synchronized
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] drv
);

  logic         pclk_prev;
  logic         pclk_rise;
  logic         load;
  logic [W-1:0] store_q;
  logic         drv_q;

  // Edge detect on the synchronized port clock.
  always_ff @(posedge clk) begin
    if (rst) pclk_prev <= 1'b0;
    else     pclk_prev <= ctl.pclk;
  end

  assign pclk_rise = ctl.pclk & ~pclk_prev;

  // Merged latch/register: open latch wins, else gated edge capture.
  assign load = ctl.le | (pclk_rise & ~ctl.cke_n);

  always_ff @(posedge clk) begin
    if (rst)       store_q <= '0;
    else if (load) store_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else     drv_q <= ~ctl.oe_n;
  end

  assign dout = store_q;
  assign drv  = {W{drv_q}};

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr
  import xcvr_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_pclk,
  input  logic         ab_cke_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_pclk,
  input  logic         ba_cke_n,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  output logic         contention
);

  xcvr_ctl_t ab_raw, ba_raw;
  xcvr_ctl_t ab_ctl_s, ba_ctl_s;
  logic [CTL_BITS-1:0] ab_sync_q, ba_sync_q;

  assign ab_raw = '{cke_n: ab_cke_n, pclk: ab_pclk, le: ab_le, oe_n: ab_oe_n};
  assign ba_raw = '{cke_n: ba_cke_n, pclk: ba_pclk, le: ba_le, oe_n: ba_oe_n};

  xcvr_sync #(.W(CTL_BITS), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ab_sync (
    .clk (clk), .rst (rst), .d (ab_raw), .q (ab_sync_q)
  );

  xcvr_sync #(.W(CTL_BITS), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ba_sync (
    .clk (clk), .rst (rst), .d (ba_raw), .q (ba_sync_q)
  );

  assign ab_ctl_s = xcvr_ctl_t'(ab_sync_q);
  assign ba_ctl_s = xcvr_ctl_t'(ba_sync_q);

  xcvr_path #(.W(W)) u_ab_path (
    .clk (clk), .rst (rst), .ctl (ab_ctl_s), .din (a_in), .dout (b_out), .drv (b_drv)
  );

  xcvr_path #(.W(W)) u_ba_path (
    .clk (clk), .rst (rst), .ctl (ba_ctl_s), .din (b_in), .dout (a_out), .drv (a_drv)
  );

  assign contention = b_drv[0] & a_drv[0];

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input xcvr_ctl_t    ab_ctl_s,
  input xcvr_ctl_t    ba_ctl_s,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_drv,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_drv,
  input logic         contention
);

  // Independent edge trackers for the synchronized port clocks.
  logic ab_prev_c, ba_prev_c;
  always_ff @(posedge clk) begin
    if (rst) begin
      ab_prev_c <= 1'b0;
      ba_prev_c <= 1'b0;
    end else begin
      ab_prev_c <= ab_ctl_s.pclk;
      ba_prev_c <= ba_ctl_s.pclk;
    end
  end

  logic ab_edge_c, ba_edge_c;
  assign ab_edge_c = ab_ctl_s.pclk && !ab_prev_c;
  assign ba_edge_c = ba_ctl_s.pclk && !ba_prev_c;

  p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
    ab_ctl_s.le |=> b_out == $past(a_in));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!ab_ctl_s.le && !ab_ctl_s.cke_n && ab_edge_c) |=> b_out == $past(a_in));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ab_ctl_s.le && !ab_edge_c) |=> $stable(b_out));

  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_ctl_s.le && ab_ctl_s.cke_n) |=> $stable(b_out));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    ab_ctl_s.oe_n |=> b_drv == '0);

  p_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !ab_ctl_s.oe_n |=> &b_drv);

  p_reset_r6: assert property (@(posedge clk)
    rst |=> (b_out == '0 && a_out == '0 && b_drv == '0 && a_drv == '0 && !contention));

  p_mirror_transp_r9: assert property (@(posedge clk) disable iff (rst)
    ba_ctl_s.le |=> a_out == $past(b_in));

  p_mirror_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ba_ctl_s.le && !(ba_edge_c && !ba_ctl_s.cke_n)) |=> $stable(a_out));

  p_mirror_drive_r9: assert property (@(posedge clk) disable iff (rst)
    ba_ctl_s.oe_n |=> a_drv == '0);

  p_contention_r10: assert property (@(posedge clk) disable iff (rst)
    (|a_drv && |b_drv) |-> contention);

  p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
    (a_drv == '0 || b_drv == '0) |-> !contention);

endmodule

bind bidir_store_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ab_ctl_s   (ab_ctl_s),
  .ba_ctl_s   (ba_ctl_s),
  .a_in       (a_in),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_drv      (b_drv),
  .a_out      (a_out),
  .a_drv      (a_drv),
  .contention (contention)
);

// File: tb/bidir_store_xcvr_tb_top.sv
module bidir_store_xcvr_tb_top;

  localparam int W = 18;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_pclk = 1'b0, ab_cke_n = 1'b1;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_pclk = 1'b0, ba_cke_n = 1'b1;
  logic [W-1:0] b_out, b_drv, a_out, a_drv;
  logic contention;

  always #5 clk = ~clk;

  bidir_store_xcvr #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .a_in (a_in), .b_in (b_in),
    .ab_oe_n (ab_oe_n), .ab_le (ab_le), .ab_pclk (ab_pclk), .ab_cke_n (ab_cke_n),
    .ba_oe_n (ba_oe_n), .ba_le (ba_le), .ba_pclk (ba_pclk), .ba_cke_n (ba_cke_n),
    .b_out (b_out), .b_drv (b_drv), .a_out (a_out), .a_drv (a_drv),
    .contention (contention)
  );

  typedef struct {
    string        req;
    logic [W-1:0] bo;
    logic         bd;
    logic [W-1:0] ao;
    logic         ad;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state kept by the driver.
  logic [W-1:0] m_b = '0, m_a = '0;
  logic         m_bd = 1'b0, m_ad = 1'b0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_now(input string req);
    item_t it;
    it.req = req; it.bo = m_b; it.bd = m_bd; it.ao = m_a; it.ad = m_ad;
    sb_q.push_back(it);
  endtask

  // Monitor: compares one cycle-unit after the falling edge, while outputs are steady.
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] ebd, ead;
      it  = sb_q.pop_front();
      ebd = {W{it.bd}};
      ead = {W{it.ad}};
      n_vec++;
      if (b_out !== it.bo) begin
        n_bad++; $display("FAIL %s b_out actual=%h expected=%h", it.req, b_out, it.bo);
      end
      if (b_drv !== ebd) begin
        n_bad++; $display("FAIL %s b_drv actual=%h expected=%h", it.req, b_drv, ebd);
      end
      if (a_out !== it.ao) begin
        n_bad++; $display("FAIL %s a_out actual=%h expected=%h", it.req, a_out, it.ao);
      end
      if (a_drv !== ead) begin
        n_bad++; $display("FAIL %s a_drv actual=%h expected=%h", it.req, a_drv, ead);
      end
      if (contention !== (it.bd & it.ad)) begin
        n_bad++; $display("FAIL %s contention actual=%b expected=%b", it.req, contention, it.bd & it.ad);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 18'h2AAAA; pats[1] = 18'h15555; pats[2] = 18'h3FFFF; pats[3] = 18'h0F0F0;

    // R6: reset state
    step(4);
    rst = 1'b0;
    expect_now("R6");
    step(2);
    expect_now("R6");

    // R7: drive enable appears on the third edge, not the second
    ab_oe_n = 1'b0;
    step(2);
    expect_now("R7");
    step(1);
    m_bd = 1'b1;
    expect_now("R5");

    // R1: pass-through with one cycle of latency, several patterns
    ab_le = 1'b1;
    step(3);
    for (int i = 0; i < 4; i++) begin
      a_in = pats[i];
      step(1);
      m_b = pats[i];
      expect_now("R1");
    end

    // R3: latch closed with clock low holds
    a_in = 18'h15555;
    step(1);
    m_b = 18'h15555;
    ab_le = 1'b0;
    step(3);
    a_in = 18'h3FFFF;
    step(2);
    expect_now("R3");

    // R2: gated-open rising edge captures
    ab_cke_n = 1'b0;
    step(3);
    expect_now("R3");
    ab_pclk = 1'b1;
    step(3);
    m_b = 18'h3FFFF;
    expect_now("R2");
    a_in = 18'h00001;
    step(3);
    expect_now("R3");
    ab_pclk = 1'b0;
    step(3);
    expect_now("R3");
    ab_pclk = 1'b1;
    step(3);
    m_b = 18'h00001;
    expect_now("R2");

    // R4: gate closed, rising edge ignored
    ab_cke_n = 1'b1;
    step(3);
    ab_pclk = 1'b0;
    step(3);
    a_in = 18'h20000;
    ab_pclk = 1'b1;
    step(3);
    expect_now("R4");

    // R8: latch closes while clock high
    ab_cke_n = 1'b0;
    step(3);
    expect_now("R8");
    ab_le = 1'b1;
    step(3);
    m_b = 18'h20000;
    expect_now("R1");
    ab_le = 1'b0;
    step(3);
    a_in = 18'h0F0F0;
    step(1);
    expect_now("R8");
    ab_pclk = 1'b0;
    step(3);
    expect_now("R8");
    ab_pclk = 1'b1;
    step(3);
    m_b = 18'h0F0F0;
    expect_now("R8");

    // R5: release keeps data, clears drive
    ab_oe_n = 1'b1;
    step(3);
    m_bd = 1'b0;
    expect_now("R5");

    // R9: B-to-A path, independent of A-to-B
    ba_oe_n = 1'b0;
    ba_le = 1'b1;
    b_in = 18'h12345;
    step(3);
    m_a = 18'h12345; m_ad = 1'b1;
    expect_now("R9");
    b_in = 18'h3C3C3;
    step(1);
    m_a = 18'h3C3C3;
    expect_now("R9");
    ba_cke_n = 1'b0;
    ba_le = 1'b0;
    step(3);
    b_in = 18'h00FF0;
    step(1);
    expect_now("R9");
    ba_pclk = 1'b1;
    step(3);
    m_a = 18'h00FF0;
    expect_now("R9");

    // R10: both drive -> contention; one released -> clear
    ab_oe_n = 1'b0;
    step(3);
    m_bd = 1'b1;
    expect_now("R10");
    ba_oe_n = 1'b1;
    step(3);
    m_ad = 1'b0;
    expect_now("R10");

    step(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule